// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the control logic that keeps a five-stage in-order pipeline (fetch, decode, register read, ALU execute, write-back) correct when instructions depend on each other or when a branch changes the flow of control. Each cycle it looks at the two source register indices of the instruction in decode. It compares them with the destination indices of the older instructions further down the pipe. For each operand it chooses where the value comes from: the ALU-stage result, the write-back-stage result or the register file. If the value does not exist yet, it stalls.

A stall holds the program counter and the fetch and decode pipeline registers, and the surrounding datapath puts a bubble into register read. Branches resolve in the ALU stage. When a branch is taken, the block clears the younger stages that hold wrong-path instructions. In normal mode it clears all three (fetch, decode, register read). In delay-slot mode the instruction right behind the branch, which sits in register read, is kept, and only fetch and decode are cleared. The block is purely combinational. Its outputs drive the stall enables, the bubble insertion and the operand multiplexers of a datapath that is not part of this block.

Top module: `hazard_ctl`

## Requirements
- R1: When decode is valid and a source index is nonzero and matches the ALU stage's destination, with that stage valid and writing, the operand select is 2'b10 (ALU result).
- R2: When a nonzero source has no writing ALU-stage match but matches a valid, writing write-back stage, the operand select is 2'b01 (write-back result).
- R3: When a source matches both the ALU stage and the write-back stage, the ALU stage wins and the select is 2'b10.
- R4: A source index of 0 always selects 2'b00 (register file) and never causes a stall. A source with no qualifying match also selects 2'b00.
- R5: `stall` is 1 when decode is valid and either nonzero source matches the destination of a valid, writing register-read stage, unless a flush is active.
- R6: Stages that are invalid, or whose write enable is 0, are ignored. With decode invalid, both selects are 2'b00 and `stall` is 0.
- R7: A taken branch in a valid ALU stage with delay-slot mode off gives `flush` = 3'b111. Bit 0 clears fetch, bit 1 clears decode and bit 2 clears register read.
- R8: A taken branch in a valid ALU stage with delay-slot mode on gives `flush` = 3'b011, so the instruction in register read is kept.
- R9: When a flush is active, `stall` is 0 even if a load-use match exists.
- R10: The branch-taken input has no effect while the ALU stage is invalid. `flush` is then 3'b000.
- R11: The two operand selects are computed independently. Each can name a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_vld | input | 1 | Decode stage holds a real instruction |
| dec_rs1 | input | REG_W | First source register index in decode |
| dec_rs2 | input | REG_W | Second source register index in decode |
| rr_vld | input | 1 | Register-read stage valid |
| rr_rd | input | REG_W | Register-read stage destination index |
| rr_we | input | 1 | Register-read stage writes its destination |
| ex_vld | input | 1 | ALU stage valid |
| ex_rd | input | REG_W | ALU stage destination index |
| ex_we | input | 1 | ALU stage writes its destination |
| ex_br_taken | input | 1 | Branch in the ALU stage resolved as taken |
| wb_vld | input | 1 | Write-back stage valid |
| wb_rd | input | REG_W | Write-back stage destination index |
| wb_we | input | 1 | Write-back stage writes its destination |
| dslot_en | input | 1 | Delay-slot mode: keep the instruction after a branch |
| fwd_a | output | 2 | Select for the first operand: 00 regfile, 01 write-back, 10 ALU |
| fwd_b | output | 2 | Select for the second operand, same coding |
| stall | output | 1 | Hold PC and fetch/decode registers, bubble into register read |
| flush | output | 3 | Clear fetch (bit 0), decode (bit 1), register read (bit 2) |

## Verification
The block holds no state, so any fault in its compare or priority logic shows up at the ports in the same cycle as the input pattern that triggers it. A wrong priority returns a select code that differs from the one the requirements predict for that combination of valid bits, write enables and indices. A broken flush or stall merge shows a stall during a branch, or the wrong flush vector for the chosen mode. Because every combination of control bits is swept against a small set of register indices, a fault in any single comparison or qualifier is exercised directly.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Operand source select codes driven to the datapath muxes
    typedef enum logic [1:0] {
        FWD_RF = 2'b00,
        FWD_WB = 2'b01,
        FWD_EX = 2'b10
    } fwd_sel_e;

    // Kind of squash requested for the younger stages
    typedef enum logic [1:0] {
        SQ_NONE = 2'b00,
        SQ_FULL = 2'b01,
        SQ_SLOT = 2'b10
    } squash_e;

    localparam int unsigned NUM_SRC  = 2;
    localparam int unsigned NUM_YNG  = 3;

endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
    import hazard_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             dec_vld,
    input  logic             rr_vld,
    input  logic [REG_W-1:0] rr_rd,
    input  logic             rr_we,
    input  logic             ex_vld,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             wb_vld,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    output fwd_sel_e         sel,
    output logic             load_use
);

    logic src_live;
    logic hit_rr;
    logic hit_ex;
    logic hit_wb;

    // Register 0 and bubbles in decode never take part in hazard checks
    assign src_live = dec_vld && (src != '0);
    assign hit_rr   = src_live && rr_vld && rr_we && (rr_rd == src);
    assign hit_ex   = src_live && ex_vld && ex_we && (ex_rd == src);
    assign hit_wb   = src_live && wb_vld && wb_we && (wb_rd == src);

    always_comb begin
        unique case ({hit_ex, hit_wb})
            2'b10, 2'b11: sel = FWD_EX;
            2'b01:        sel = FWD_WB;
            default:      sel = FWD_RF;
        endcase
    end

    assign load_use = hit_rr;

endmodule

// File: rtl/hz_squash_gen.sv
module hz_squash_gen
    import hazard_pkg::*;
#(
    parameter int unsigned NYNG = NUM_YNG
) (
    input  logic            br_fire,
    input  logic            dslot_en,
    output logic [NYNG-1:0] flush
);

    localparam logic [NYNG-1:0] ALL_YNG  = {NYNG{1'b1}};
    localparam logic [NYNG-1:0] KEEP_OLD = ALL_YNG >> 1;

    squash_e mode;

    always_comb begin
        if (!br_fire)      mode = SQ_NONE;
        else if (dslot_en) mode = SQ_SLOT;
        else               mode = SQ_FULL;
    end

    always_comb begin
        unique case (mode)
            SQ_FULL: flush = ALL_YNG;
            SQ_SLOT: flush = KEEP_OLD;
            default: flush = '0;
        endcase
    end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hazard_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic             dec_vld,
    input  logic [REG_W-1:0] dec_rs1,
    input  logic [REG_W-1:0] dec_rs2,
    input  logic             rr_vld,
    input  logic [REG_W-1:0] rr_rd,
    input  logic             rr_we,
    input  logic             ex_vld,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_br_taken,
    input  logic             wb_vld,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_we,
    input  logic             dslot_en,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             stall,
    output logic [2:0]       flush
);

    logic [REG_W-1:0] src_idx [NUM_SRC];
    fwd_sel_e         src_sel [NUM_SRC];
    logic [NUM_SRC-1:0] src_lu;
    logic [NUM_YNG-1:0] sq_vec;

    assign src_idx[0] = dec_rs1;
    assign src_idx[1] = dec_rs2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_operand_sel #(.REG_W(REG_W)) u_sel (
            .src      (src_idx[g]),
            .dec_vld  (dec_vld),
            .rr_vld   (rr_vld),
            .rr_rd    (rr_rd),
            .rr_we    (rr_we),
            .ex_vld   (ex_vld),
            .ex_rd    (ex_rd),
            .ex_we    (ex_we),
            .wb_vld   (wb_vld),
            .wb_rd    (wb_rd),
            .wb_we    (wb_we),
            .sel      (src_sel[g]),
            .load_use (src_lu[g])
        );
    end

    hz_squash_gen #(.NYNG(NUM_YNG)) u_squash (
        .br_fire  (ex_vld && ex_br_taken),
        .dslot_en (dslot_en),
        .flush    (sq_vec)
    );

    assign fwd_a = src_sel[0];
    assign fwd_b = src_sel[1];
    assign flush = sq_vec;
    // a squash wins: the stalled decode instruction is on the wrong path
    assign stall = (|src_lu) && !(|sq_vec);

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
    parameter int unsigned REG_W = 5
) (
    input logic             dec_vld,
    input logic [REG_W-1:0] dec_rs1,
    input logic [REG_W-1:0] dec_rs2,
    input logic             ex_vld,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_we,
    input logic             ex_br_taken,
    input logic             dslot_en,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             stall,
    input logic [2:0]       flush
);

    always_comb begin
        a_r9_flush_over_stall: assert (!(stall && (flush != 3'b000)));
        a_r7_full_squash: assert (!(ex_vld && ex_br_taken && !dslot_en) || flush == 3'b111);
        a_r8_slot_kept: assert (!(ex_vld && ex_br_taken && dslot_en) || flush == 3'b011);
        a_r10_no_fire: assert ((ex_vld && ex_br_taken) || flush == 3'b000);
        a_r4_zero_src: assert ((dec_rs1 != '0 || fwd_a == 2'b00) && (dec_rs2 != '0 || fwd_b == 2'b00));
        a_r6_idle_decode: assert (dec_vld || (fwd_a == 2'b00 && fwd_b == 2'b00 && !stall));
        a_r1_ex_hit: assert (!(dec_vld && ex_vld && ex_we && dec_rs1 != '0 && ex_rd == dec_rs1) || fwd_a == 2'b10);
        a_r11_legal_codes: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    end

endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
    .dec_vld     (dec_vld),
    .dec_rs1     (dec_rs1),
    .dec_rs2     (dec_rs2),
    .ex_vld      (ex_vld),
    .ex_rd       (ex_rd),
    .ex_we       (ex_we),
    .ex_br_taken (ex_br_taken),
    .dslot_en    (dslot_en),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .stall       (stall),
    .flush       (flush)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;

    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          dec_vld, rr_vld, rr_we, ex_vld, ex_we, ex_br_taken, wb_vld, wb_we, dslot_en;
    logic [RW-1:0] dec_rs1, dec_rs2, rr_rd, ex_rd, wb_rd;
    logic [1:0]    fwd_a, fwd_b;
    logic          stall;
    logic [2:0]    flush;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    hazard_ctl #(.REG_W(RW)) u_dut (
        .dec_vld(dec_vld), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .rr_vld(rr_vld), .rr_rd(rr_rd), .rr_we(rr_we),
        .ex_vld(ex_vld), .ex_rd(ex_rd), .ex_we(ex_we), .ex_br_taken(ex_br_taken),
        .wb_vld(wb_vld), .wb_rd(wb_rd), .wb_we(wb_we), .dslot_en(dslot_en),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .flush(flush)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sel(input logic [RW-1:0] s);
        if (!dec_vld || s == 0) return 0;
        if (ex_vld && ex_we && ex_rd == s) return 2;
        if (wb_vld && wb_we && wb_rd == s) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(input logic [RW-1:0] s, input int e);
        if (e == 2) return (wb_vld && wb_we && wb_rd == s) ? "R3 ex over wb" : "R1 ex select";
        if (e == 1) return "R2 wb select";
        if (!dec_vld) return "R6 idle decode";
        return "R4 regfile select";
    endfunction

    function automatic int exp_flush();
        if (!(ex_vld && ex_br_taken)) return 0;
        return dslot_en ? 3 : 7;
    endfunction

    function automatic bit lu_hit();
        return dec_vld && rr_vld && rr_we && rr_rd != 0 &&
               (rr_rd == dec_rs1 || rr_rd == dec_rs2);
    endfunction

    task automatic check_all();
        int ef;
        ef = exp_flush();
        check(sel_tag(dec_rs1, exp_sel(dec_rs1)), fwd_a, exp_sel(dec_rs1));
        check(sel_tag(dec_rs2, exp_sel(dec_rs2)), fwd_b, exp_sel(dec_rs2));
        check((lu_hit() && ef != 0) ? "R9 flush over stall" : "R5 stall", stall,
              (lu_hit() && ef == 0) ? 1 : 0);
        check(ef == 7 ? "R7 full squash" : (ef == 3 ? "R8 delay slot" : "R10 no squash"),
              flush, ef);
    endtask

    task automatic idle_inputs();
        {dec_vld, rr_vld, rr_we, ex_vld, ex_we, ex_br_taken, wb_vld, wb_we, dslot_en} = '0;
        {dec_rs1, dec_rs2, rr_rd, ex_rd, wb_rd} = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: all stages idle, nothing forwarded, stalled or flushed
        check("R6 idle fwd_a", fwd_a, 0);
        check("R6 idle fwd_b", fwd_b, 0);
        check("R6 idle stall", stall, 0);
        check("R10 idle flush", flush, 0);

        // R11: operands pick different sources in the same cycle
        @(posedge clk);
        dec_vld = 1; dec_rs1 = 5'd7; dec_rs2 = 5'd9;
        ex_vld = 1; ex_we = 1; ex_rd = 5'd7;
        wb_vld = 1; wb_we = 1; wb_rd = 5'd9;
        @(negedge clk);
        check("R11 fwd_a ex", fwd_a, 2);
        check("R11 fwd_b wb", fwd_b, 1);

        // Sweep: every control combination against indices 0..2
        for (int c = 0; c < 512; c++) begin
            for (int r = 0; r < 243; r++) begin
                @(posedge clk);
                {dec_vld, rr_vld, rr_we, ex_vld, ex_we, wb_vld, wb_we, ex_br_taken, dslot_en} = c[8:0];
                dec_rs1 = RW'(r % 3);
                dec_rs2 = RW'((r / 3) % 3);
                rr_rd   = RW'((r / 9) % 3);
                ex_rd   = RW'((r / 27) % 3);
                wb_rd   = RW'((r / 81) % 3);
                @(negedge clk);
                check_all();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule